// File: doc/BRIEF.md
# Flash Erase Failure Recovery Sequencer

This controller sits on the host side of a byte-wide flash command/address/data bus. It runs one complete write transaction: erase a block in one bank, or in each of two banks. While the erase is busy it loads the program data for one page per bank. It then reads the erase result. If an erase failed, the loaded page data is kept. No reset command is issued, so the buffered data survives. A substitute block in the same bank is erased instead, and this is retried up to a fixed limit. The program target is then re-aimed with address-only re-specify cycles, programming is started, and the program result is read back.

The host supplies the erase rows, the substitute rows, the page rows, a column address and a mode bit (single or dual bank), and pulses `start`. The page data arrives on a valid/ready byte stream: bank 0's bytes first, then bank 1's. The block raises `done` with a two-bit result code and holds it until the next `start`. Every bus cycle is a one-clock strobe (`fl_we` with `fl_cle` or `fl_ale`, or `fl_re`), and no strobe is issued while the ready/busy input is low.

Top module: `flash_erase_recover`

## Requirements
- R1: The erase setup sends command 60h and then the erase row as two address bytes, low byte first. This happens for bank 0 and then, in dual mode, for bank 1. A single D0h command follows the last bank.
- R2: After the first erase, each bank receives the page load: command 80h, column low, column high, page row low, page row high, and then DATA_LEN data bytes taken from the stream in order. In dual mode bank 0's load ends with command 11h; the last bank's load ends without a command.
- R3: After each erase and after programming, command 70h is sent and status bytes are read until bit 6 is 1. Bit 0 = 1 means failure. In dual mode bits 1 and 2 name the failing bank (bank 0, bank 1); if both are 0, both banks are treated as failed. In single mode only bit 0 is used.
- R4: After a failed erase, only the failing banks are erased again at their substitute rows (60h, row low, row high per bank, then D0h). Command FFh is never issued.
- R5: After a passing erase, each bank gets 85h, column low, column high, row low, row high. The row is the substitute row if that bank was ever substituted, otherwise the page row. Every bank but the last ends with 11h, and the last ends with 10h.
- R6: After MAX_RETRY substitute erases have failed, the sequencer stops with `err_code` = 2 and issues no more cycles.
- R7: No strobe is driven while `fl_rb` is low. If TIMEOUT consecutive cycles pass waiting on ready/busy or on status bit 6, the sequencer stops with `err_code` = 1.
- R8: If the final program status has bit 0 set, `err_code` = 3; otherwise `err_code` = 0.
- R9: After reset no strobe is active, `din_ready` = 0, `done` = 0 and `err_code` = 0.
- R10: `start` is ignored while a transaction runs. `done` and `err_code` hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle or finished) |
| dual | input | 1 | 1 = two-bank transaction, 0 = bank 0 only |
| er_row0 | input | 16 | Erase row, bank 0 |
| er_row1 | input | 16 | Erase row, bank 1 |
| sub_row0 | input | 16 | Substitute block row, bank 0 |
| sub_row1 | input | 16 | Substitute block row, bank 1 |
| pg_row0 | input | 16 | Page row to program, bank 0 |
| pg_row1 | input | 16 | Page row to program, bank 1 |
| col_addr | input | 16 | Column address for load and re-specify |
| din | input | 8 | Page data byte |
| din_valid | input | 1 | Data byte valid |
| din_ready | output | 1 | Sequencer takes the data byte this cycle when valid |
| fl_rb | input | 1 | Flash ready (1) / busy (0) |
| fl_din | input | 8 | Status byte from the flash, sampled while `fl_re` is high |
| fl_we | output | 1 | Write strobe for one bus cycle |
| fl_re | output | 1 | Status read strobe |
| fl_cle | output | 1 | Current write cycle is a command |
| fl_ale | output | 1 | Current write cycle is an address byte |
| fl_dq | output | 8 | Byte driven during a write cycle |
| done | output | 1 | Transaction finished |
| err_code | output | 2 | 0 ok, 1 timeout, 2 retries exhausted, 3 program failed |

## Verification
A behavioural flash model logs every write cycle. It answers status reads from a per-attempt script of bank failure masks, and its busy periods follow D0h, 11h and 10h. The sweep runs both modes against every bank-0/bank-1 first-erase failure mask, each with a passing and a failing program. This separates the pass path from substitution in either or both banks, and shows that single mode ignores the bank-1 bits. Scripted multi-attempt failures distinguish a recovery on the last allowed retry from the retry-exhausted stop. A model whose busy line never returns separates the timeout exit from normal completion. The data stream stalls every third cycle, so out-of-order or dropped bytes show up in the log.

// File: rtl/flash_erase_recover.sv
module flash_erase_recover #(
  parameter int DATA_LEN  = 4,
  parameter int TIMEOUT   = 256,
  parameter int MAX_RETRY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dual,
  input  logic [15:0] er_row0,
  input  logic [15:0] er_row1,
  input  logic [15:0] sub_row0,
  input  logic [15:0] sub_row1,
  input  logic [15:0] pg_row0,
  input  logic [15:0] pg_row1,
  input  logic [15:0] col_addr,
  input  logic [7:0]  din,
  input  logic        din_valid,
  output logic        din_ready,
  input  logic        fl_rb,
  input  logic [7:0]  fl_din,
  output logic        fl_we,
  output logic        fl_re,
  output logic        fl_cle,
  output logic        fl_ale,
  output logic [7:0]  fl_dq,
  output logic        done,
  output logic [1:0]  err_code
);
  localparam int IW = $clog2(DATA_LEN + 8);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int RW = $clog2(MAX_RETRY + 2);
  localparam logic [IW-1:0] I1 = IW'(1), I2 = IW'(2), I3 = IW'(3), I4 = IW'(4), I5 = IW'(5);
  localparam logic [IW-1:0] I_LAST = IW'(4 + DATA_LEN);
  localparam logic [IW-1:0] I_QUEUE = IW'(5 + DATA_LEN);
  localparam logic [1:0] K_NONE = 2'd0, K_CMD = 2'd1, K_ADR = 2'd2, K_DAT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ERA, S_LOAD, S_STC, S_POLL, S_RESP, S_FIN} st_t;
  st_t st;

  logic [IW-1:0] idx;
  logic [1:0]    mask, used, err;
  logic          first, ctx, dl;
  logic [RW-1:0] retry;
  logic [TW-1:0] tcnt;
  logic [15:0]   er0, er1, sb0, sb1, pg0, pg1, col;

  logic          cb, more, fire, stall, tout, rdy;
  logic [1:0]    kind, fm;
  logic [7:0]    dq;
  logic [15:0]   erow, prow, rrow;

  assign cb   = ~mask[0];
  assign more = (mask == 2'b11);
  assign erow = cb ? (used[1] ? sb1 : er1) : (used[0] ? sb0 : er0);
  assign prow = cb ? pg1 : pg0;
  assign rrow = cb ? (used[1] ? sb1 : pg1) : (used[0] ? sb0 : pg0);

  always_comb begin
    kind = K_NONE;
    dq   = 8'h00;
    case (st)
      S_ERA:
        if (mask != 2'b00) begin
          if (idx == '0)      begin kind = K_CMD; dq = 8'h60; end
          else if (idx == I1) begin kind = K_ADR; dq = erow[7:0]; end
          else                begin kind = K_ADR; dq = erow[15:8]; end
        end else begin
          kind = K_CMD; dq = 8'hD0;
        end
      S_LOAD:
        if (idx == '0)          begin kind = K_CMD; dq = 8'h80; end
        else if (idx == I1)     begin kind = K_ADR; dq = col[7:0]; end
        else if (idx == I2)     begin kind = K_ADR; dq = col[15:8]; end
        else if (idx == I3)     begin kind = K_ADR; dq = prow[7:0]; end
        else if (idx == I4)     begin kind = K_ADR; dq = prow[15:8]; end
        else if (idx < I_QUEUE) begin kind = K_DAT; dq = din; end
        else                    begin kind = K_CMD; dq = 8'h11; end
      S_RESP:
        if (idx == '0)      begin kind = K_CMD; dq = 8'h85; end
        else if (idx == I1) begin kind = K_ADR; dq = col[7:0]; end
        else if (idx == I2) begin kind = K_ADR; dq = col[15:8]; end
        else if (idx == I3) begin kind = K_ADR; dq = rrow[7:0]; end
        else if (idx == I4) begin kind = K_ADR; dq = rrow[15:8]; end
        else                begin kind = K_CMD; dq = more ? 8'h11 : 8'h10; end
      S_STC: begin kind = K_CMD; dq = 8'h70; end
      default: ;
    endcase
  end

  assign fire      = (kind != K_NONE) && fl_rb && ((kind != K_DAT) || din_valid);
  assign din_ready = (kind == K_DAT) && fl_rb;
  assign fl_we     = fire;
  assign fl_cle    = fire && (kind == K_CMD);
  assign fl_ale    = fire && (kind == K_ADR);
  assign fl_dq     = fire ? dq : 8'h00;
  assign fl_re     = (st == S_POLL) && fl_rb;
  assign rdy       = fl_re && fl_din[6];
  assign stall     = (((kind != K_NONE) || (st == S_POLL)) && !fl_rb) ||
                     ((st == S_POLL) && fl_rb && !fl_din[6]);
  assign tout      = stall && (tcnt == TW'(TIMEOUT - 1));
  assign fm        = !fl_din[0] ? 2'b00 : !dl ? 2'b01 :
                     (|fl_din[2:1]) ? fl_din[2:1] : 2'b11;
  assign done      = (st == S_FIN);
  assign err_code  = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; mask <= '0; used <= '0; err <= '0;
      first <= 1'b0; ctx <= 1'b0; dl <= 1'b0; retry <= '0; tcnt <= '0;
      er0 <= '0; er1 <= '0; sb0 <= '0; sb1 <= '0; pg0 <= '0; pg1 <= '0; col <= '0;
    end else if (start && (st == S_IDLE || st == S_FIN)) begin
      er0 <= er_row0; er1 <= er_row1; sb0 <= sub_row0; sb1 <= sub_row1;
      pg0 <= pg_row0; pg1 <= pg_row1; col <= col_addr; dl <= dual;
      st <= S_ERA; mask <= dual ? 2'b11 : 2'b01; idx <= '0; first <= 1'b1;
      used <= '0; retry <= '0; tcnt <= '0; err <= '0; ctx <= 1'b0;
    end else if (tout) begin
      st <= S_FIN; err <= 2'd1;
    end else begin
      tcnt <= stall ? tcnt + 1'b1 : '0;
      if (fire) begin
        case (st)
          S_ERA:
            if (mask != 2'b00) begin
              if (idx == I2) begin mask[cb] <= 1'b0; idx <= '0; end
              else idx <= idx + 1'b1;
            end else begin
              ctx <= 1'b0;
              if (first) begin st <= S_LOAD; mask <= dl ? 2'b11 : 2'b01; first <= 1'b0; end
              else st <= S_STC;
            end
          S_LOAD:
            if ((idx == I_LAST && !more) || idx == I_QUEUE) begin
              mask[cb] <= 1'b0; idx <= '0;
              if (!more) st <= S_STC;
            end else idx <= idx + 1'b1;
          S_RESP:
            if (idx == I5) begin
              mask[cb] <= 1'b0; idx <= '0;
              if (!more) begin st <= S_STC; ctx <= 1'b1; end
            end else idx <= idx + 1'b1;
          S_STC: st <= S_POLL;
          default: ;
        endcase
      end
      if (rdy) begin
        if (ctx) begin
          st <= S_FIN; err <= fl_din[0] ? 2'd3 : 2'd0;
        end else if (fm == 2'b00) begin
          st <= S_RESP; mask <= dl ? 2'b11 : 2'b01; idx <= '0;
        end else if (retry == RW'(MAX_RETRY)) begin
          st <= S_FIN; err <= 2'd2;
        end else begin
          retry <= retry + 1'b1; used <= used | fm; mask <= fm; idx <= '0; st <= S_ERA;
        end
      end
    end
  end

  a_r4_no_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cle |-> fl_dq != 8'hFF);
  a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> fl_rb);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fl_re, fl_cle, fl_ale}) <= 1 && !(fl_re && fl_we));
  a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= RW'(MAX_RETRY));
  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(err_code));
  a_r6_silent_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fl_we && !fl_re && !din_ready);
  a_r2_data_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && !fl_cle && !fl_ale) |-> din_valid);
endmodule

// File: tb/flash_erase_recover_tb_top.sv
module flash_erase_recover_tb_top;
  localparam int CLK_P = 10;
  localparam int N  = 3;
  localparam int TO = 32;
  localparam int MR = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dual = 1'b0, mclr = 1'b0;
  logic [15:0] er0 = 16'h1200, er1 = 16'h2340, sb0 = 16'h1280, sb1 = 16'h23C0;
  logic [15:0] pg0 = 16'h1204, pg1 = 16'h2345, col = 16'h0010;
  logic [7:0] din; logic din_valid = 1'b0; logic din_ready;
  logic fl_rb; logic [7:0] fl_din;
  logic fl_we, fl_re, fl_cle, fl_ale, done; logic [7:0] fl_dq; logic [1:0] err_code;

  always #(CLK_P/2) clk = ~clk;

  flash_erase_recover #(.DATA_LEN(N), .TIMEOUT(TO), .MAX_RETRY(MR)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dual(dual),
    .er_row0(er0), .er_row1(er1), .sub_row0(sb0), .sub_row1(sb1),
    .pg_row0(pg0), .pg_row1(pg1), .col_addr(col),
    .din(din), .din_valid(din_valid), .din_ready(din_ready),
    .fl_rb(fl_rb), .fl_din(fl_din), .fl_we(fl_we), .fl_re(fl_re),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_dq(fl_dq),
    .done(done), .err_code(err_code));

  // flash model and stream source
  logic [1:0] fcfg [0:3];
  logic cfg_d = 1'b0, cfg_pf = 1'b0, cfg_hang = 1'b0;
  logic [9:0] lg [0:255];
  integer ln = 0, att = 0, rb_cnt = 0, busy_rd = 0, k = 0, gcnt = 0;
  logic hang_now = 1'b0;
  logic [7:0] mstat = 8'h00;

  assign fl_rb  = (rb_cnt == 0) && !hang_now;
  assign fl_din = (busy_rd > 0) ? 8'h00 : (mstat | 8'h40);
  assign din    = 8'h30 + k[7:0];

  always @(posedge clk) begin
    gcnt <= gcnt + 1;
    din_valid <= (gcnt % 3) != 1;
    if (!rst_n || mclr) begin
      ln <= 0; att <= 0; rb_cnt <= 0; busy_rd <= 0; hang_now <= 1'b0; mstat <= 8'h00; k <= 0;
    end else begin
      if (din_valid && din_ready) k <= k + 1;
      if (rb_cnt > 0) rb_cnt <= rb_cnt - 1;
      if (fl_re && busy_rd > 0) busy_rd <= busy_rd - 1;
      if (fl_we) begin
        lg[ln] <= {fl_cle ? 2'd1 : fl_ale ? 2'd2 : 2'd3, fl_dq};
        ln <= ln + 1;
        if (fl_cle && fl_dq == 8'hD0) begin
          rb_cnt <= 3; busy_rd <= 3; att <= att + 1;
          mstat <= cfg_d ? {5'b0, fcfg[att], |fcfg[att]} : {7'b0, fcfg[att][0]};
          if (cfg_hang) hang_now <= 1'b1;
        end
        if (fl_cle && fl_dq == 8'h11) rb_cnt <= 2;
        if (fl_cle && fl_dq == 8'h10) begin rb_cnt <= 4; busy_rd <= 2; mstat <= {7'b0, cfg_pf}; end
      end
    end
  end

  integer n_chk = 0, n_fail = 0, cyc = 0;
  logic [9:0] ex [0:255];
  integer en;

  task automatic chk(input logic ok, input string tag, input integer act, input integer expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic push(input logic [1:0] t, input logic [7:0] v);
    ex[en] = {t, v}; en++;
  endtask

  function automatic logic [15:0] row_of(input int sel, input int b);
    case (sel)
      0: return b ? er1 : er0;
      1: return b ? sb1 : sb0;
      default: return b ? pg1 : pg0;
    endcase
  endfunction

  task automatic run(input logic d, input logic [1:0] f0, input logic [1:0] f1,
                     input logic [1:0] f2, input logic [1:0] f3, input logic pf,
                     input logic hang, input logic midstart, input string tag);
    logic [1:0] fl [0:3];
    logic [1:0] fm, used;
    integer r, eerr, w, mism, nb;
    logic [15:0] rw;
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    @(negedge clk);
    fcfg[0] = f0; fcfg[1] = f1; fcfg[2] = f2; fcfg[3] = f3;
    cfg_d = d; cfg_pf = pf; cfg_hang = hang; dual = d; mclr = 1'b1;
    @(negedge clk); mclr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 3000) begin
      @(negedge clk); w++;
      if (midstart && w == 12) begin start = 1'b1; dual = ~d; end
      if (midstart && w == 13) begin start = 1'b0; dual = d; end
    end
    en = 0; nb = d ? 2 : 1; eerr = 0; used = 2'b00;
    for (int b = 0; b < nb; b++) begin rw = row_of(0, b); push(1, 8'h60); push(2, rw[7:0]); push(2, rw[15:8]); end
    push(1, 8'hD0);
    if (hang) eerr = 1;
    else begin
      for (int b = 0; b < nb; b++) begin
        rw = row_of(2, b);
        push(1, 8'h80); push(2, col[7:0]); push(2, col[15:8]); push(2, rw[7:0]); push(2, rw[15:8]);
        for (int i = 0; i < N; i++) push(3, 8'h30 + 8'(b * N + i));
        if (d && b == 0) push(1, 8'h11);
      end
      push(1, 8'h70);
      r = 0; fm = d ? fl[0] : {1'b0, fl[0][0]};
      while (fm != 2'b00 && eerr == 0) begin
        if (r == MR) eerr = 2;
        else begin
          used = used | fm;
          for (int b = 0; b < 2; b++)
            if (fm[b]) begin rw = row_of(1, b); push(1, 8'h60); push(2, rw[7:0]); push(2, rw[15:8]); end
          push(1, 8'hD0); push(1, 8'h70);
          r++; fm = d ? fl[r] : {1'b0, fl[r][0]};
        end
      end
      if (eerr == 0) begin
        for (int b = 0; b < nb; b++) begin
          rw = used[b] ? row_of(1, b) : row_of(2, b);
          push(1, 8'h85); push(2, col[7:0]); push(2, col[15:8]); push(2, rw[7:0]); push(2, rw[15:8]);
          push(1, (d && b == 0) ? 8'h11 : 8'h10);
        end
        push(1, 8'h70);
        eerr = pf ? 3 : 0;
      end
    end
    chk(done, {tag, " done"}, done, 1);
    chk(err_code == eerr[1:0], {tag, " err_code"}, err_code, eerr);
    chk(ln == en, {tag, " cycle count"}, ln, en);
    mism = -1;
    for (int i = 0; i < en && i < ln; i++) if (mism < 0 && lg[i] != ex[i]) mism = i;
    if (mism >= 0) chk(1'b0, {tag, " bus cycle content"}, lg[mism], ex[mism]);
    else chk(1'b1, tag, 0, 0);
    repeat (4) @(negedge clk);
    chk(done && err_code == eerr[1:0] && ln == en, {tag, " R10 hold"}, err_code, eerr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!fl_we && !fl_re && !din_ready, "R9 strobes in reset", {fl_we, fl_re, din_ready}, 0);
    chk(!done && err_code == 2'd0, "R9 done/err in reset", {done, err_code}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!fl_we && !done && !din_ready, "R9 idle after reset", {fl_we, done}, 0);
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 4; f++)
        for (int p = 0; p < 2; p++)
          run(d[0], f[1:0], 2'b00, 2'b00, 2'b00, p[0], 1'b0, 1'b0, "R1 R2 R3 R4 R5 R8 sweep");
    run(1'b0, 2'b01, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R4 R6 recover on last retry");
    run(1'b0, 2'b01, 2'b01, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, "R6 retries exhausted");
    run(1'b1, 2'b11, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R4 R5 both then bank1");
    run(1'b1, 2'b10, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, "R6 dual exhausted");
    run(1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, "R7 busy timeout dual");
    run(1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, "R7 busy timeout single");
    run(1'b1, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, "R10 start while busy");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule